// File: doc/BRIEF.md
# Lookahead Signed Adder-Subtractor

This block is the add/subtract datapath slice of an integer ALU. It is purely combinational. It takes two N-bit operands, a select between addition and subtraction, and a carry/borrow input. From these it forms the N-bit two's complement result, the unsigned carry-out and the signed overflow flag, all in the same cycle the operands arrive.

Subtraction reuses the adder. The second operand is inverted and the missing +1 enters through the bit-0 carry. The carry-in acts as a carry in add mode and as a borrow in subtract mode.

Carries never ripple bit by bit:
- Every bit produces a generate term and a propagate term.
- Four-bit groups expand the carry recurrence into flat sum-of-products form.
- The group-level generate and propagate terms feed a second level of the same expansion, which yields the carry into each group.

Overflow is the disagreement between the carry entering the sign bit and the carry leaving it.

Top module: `lasa_addsub`

## Requirements
- R1: With `sub_i`=0, `sum_o` equals (A + B + `cin_i`) modulo 2^N.
- R2: With `sub_i`=1, `sum_o` equals (A − B − `cin_i`) modulo 2^N, so `cin_i`=1 acts as a borrow.
- R3: With `sub_i`=0, `cout_o` equals bit N of the unsigned (N+1)-bit sum A + B + `cin_i`.
- R4: With `sub_i`=1, `cout_o` is 1 exactly when unsigned A ≥ B + `cin_i` (no borrow out), else 0.
- R5: With `sub_i`=0, `ovf_o` is 1 exactly when the exact signed value A + B + `cin_i` lies outside [−2^(N−1), 2^(N−1)−1].
- R6: With `sub_i`=1, `ovf_o` is 1 exactly when the exact signed value A − B − `cin_i` lies outside that same range.
- R7: Adding the most negative value to −1 gives `ovf_o`=1 and `cout_o`=1. Subtracting the most negative value from 0 gives `ovf_o`=1 and a result equal to the most negative value.
- R8: N must be a multiple of 4 and at least 4; any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, two's complement |
| b_i | input | N | Second operand, two's complement |
| sub_i | input | 1 | 0 selects A+B, 1 selects A−B |
| cin_i | input | 1 | Carry-in when adding, borrow-in when subtracting |
| sum_o | output | N | Result, carry beyond the sign bit dropped |
| cout_o | output | 1 | Unsigned carry-out (no-borrow when subtracting) |
| ovf_o | output | 1 | Signed overflow |

## Verification
The unsigned carry-out and the signed overflow are separate judgements, yet both can be raised by one operation. Two cases show this:
- The most negative value plus itself raises both flags.
- The most negative value plus −1 raises both flags, and also exercises R7.

The bench applies these pairs directly. It also applies random operands in both modes and with both carry-in values. Each flag is judged against a behavioural reference that works from the exact integer result. That reference compares the signed value with the representable range and the unsigned value with 2^N, independently of each other.

// File: rtl/lasa_pkg.sv
package lasa_pkg;
   localparam int LASA_GRP_W = 4;

   function automatic int lasa_group_count(input int width);
      return width / LASA_GRP_W;
   endfunction
endpackage

// File: rtl/lasa_gp_bits.sv
module lasa_gp_bits #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] gen_o,
   output logic [W-1:0] prop_o
);
   always_comb begin
      gen_o  = a_i & b_i;
      prop_o = a_i ^ b_i;
   end
endmodule

// File: rtl/lasa_group_gp.sv
// Group generate / propagate of one 4-bit lookahead group.
module lasa_group_gp (
   input  logic [3:0] gen_i,
   input  logic [3:0] prop_i,
   output logic       grp_gen_o,
   output logic       grp_prop_o
);
   always_comb begin
      grp_gen_o  = gen_i[3]
                 | (prop_i[3] & gen_i[2])
                 | (prop_i[3] & prop_i[2] & gen_i[1])
                 | (prop_i[3] & prop_i[2] & prop_i[1] & gen_i[0]);
      grp_prop_o = &prop_i;
   end
endmodule

// File: rtl/lasa_group_carry.sv
// Carries into each bit of a 4-bit group, flattened from the group carry-in.
module lasa_group_carry (
   input  logic [3:0] gen_i,
   input  logic [3:0] prop_i,
   input  logic       cin_i,
   output logic [3:0] carry_o
);
   always_comb begin
      carry_o[0] = cin_i;
      carry_o[1] = gen_i[0] | (prop_i[0] & cin_i);
      carry_o[2] = gen_i[1]
                 | (prop_i[1] & gen_i[0])
                 | (prop_i[1] & prop_i[0] & cin_i);
      carry_o[3] = gen_i[2]
                 | (prop_i[2] & gen_i[1])
                 | (prop_i[2] & prop_i[1] & gen_i[0])
                 | (prop_i[2] & prop_i[1] & prop_i[0] & cin_i);
   end
endmodule

// File: rtl/lasa_carry_tree.sv
// Second lookahead level: every group carry as a flat sum of products
// of group generate/propagate terms and the block carry-in.
module lasa_carry_tree #(
   parameter int NG = 4
) (
   input  logic [NG-1:0] grp_gen_i,
   input  logic [NG-1:0] grp_prop_i,
   input  logic          cin_i,
   output logic [NG:0]   grp_carry_o
);
   always_comb begin
      logic acc;
      logic run;
      grp_carry_o[0] = cin_i;
      for (int j = 1; j <= NG; j++) begin
         acc = 1'b0;
         run = 1'b1;
         for (int k = j - 1; k >= 0; k--) begin
            acc = acc | (run & grp_gen_i[k]);
            run = run & grp_prop_i[k];
         end
         grp_carry_o[j] = acc | (run & cin_i);
      end
   end
endmodule

// File: rtl/lasa_addsub.sv
module lasa_addsub
   import lasa_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         sub_i,
   input  logic         cin_i,
   output logic [N-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);
   localparam int NG = lasa_group_count(N);

   // R8: width legality
   if (N < LASA_GRP_W || (N % LASA_GRP_W) != 0) begin : g_bad_width
      $error("lasa_addsub: N must be a positive multiple of 4");
   end

   logic [N-1:0]  b_eff;
   logic          c0;
   logic [N-1:0]  gen_w;
   logic [N-1:0]  prop_w;
   logic [N-1:0]  carry_w;
   logic [NG-1:0] grp_gen_w;
   logic [NG-1:0] grp_prop_w;
   logic [NG:0]   grp_carry_w;

   always_comb begin
      b_eff = b_i ^ {N{sub_i}};
      c0    = cin_i ^ sub_i;
   end

   lasa_gp_bits #(.W(N)) u_gp (
      .a_i    (a_i),
      .b_i    (b_eff),
      .gen_o  (gen_w),
      .prop_o (prop_w)
   );

   for (genvar gi = 0; gi < NG; gi++) begin : g_grp
      lasa_group_gp u_ggp (
         .gen_i      (gen_w [gi*LASA_GRP_W +: LASA_GRP_W]),
         .prop_i     (prop_w[gi*LASA_GRP_W +: LASA_GRP_W]),
         .grp_gen_o  (grp_gen_w[gi]),
         .grp_prop_o (grp_prop_w[gi])
      );
      lasa_group_carry u_gcy (
         .gen_i   (gen_w [gi*LASA_GRP_W +: LASA_GRP_W]),
         .prop_i  (prop_w[gi*LASA_GRP_W +: LASA_GRP_W]),
         .cin_i   (grp_carry_w[gi]),
         .carry_o (carry_w[gi*LASA_GRP_W +: LASA_GRP_W])
      );
   end

   lasa_carry_tree #(.NG(NG)) u_tree (
      .grp_gen_i   (grp_gen_w),
      .grp_prop_i  (grp_prop_w),
      .cin_i       (c0),
      .grp_carry_o (grp_carry_w)
   );

   always_comb begin
      sum_o  = prop_w ^ carry_w;
      cout_o = grp_carry_w[NG];
      ovf_o  = grp_carry_w[NG] ^ carry_w[N-1];
   end
endmodule

// File: rtl/lasa_addsub_chk.sv
module lasa_addsub_chk #(
   parameter int N = 16
) (
   input logic [N-1:0] a_i,
   input logic [N-1:0] b_i,
   input logic         sub_i,
   input logic         cin_i,
   input logic [N-1:0] sum_o,
   input logic         cout_o,
   input logic         ovf_o
);
   logic [N:0]   wide_add;
   logic [N:0]   wide_b_plus_c;
   logic [N+1:0] s_add;
   logic [N+1:0] s_sub;
   logic         s_add_bad;
   logic         s_sub_bad;
   logic         known;

   always_comb begin
      known         = !$isunknown({a_i, b_i, sub_i, cin_i, sum_o, cout_o, ovf_o});
      wide_add      = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};
      wide_b_plus_c = {1'b0, b_i} + {{N{1'b0}}, cin_i};
      s_add = {{2{a_i[N-1]}}, a_i} + {{2{b_i[N-1]}}, b_i} + {{(N+1){1'b0}}, cin_i};
      s_sub = {{2{a_i[N-1]}}, a_i} - {{2{b_i[N-1]}}, b_i} - {{(N+1){1'b0}}, cin_i};
      s_add_bad = (s_add[N+1:N-1] != 3'b000) && (s_add[N+1:N-1] != 3'b111);
      s_sub_bad = (s_sub[N+1:N-1] != 3'b000) && (s_sub[N+1:N-1] != 3'b111);

      if (known && !sub_i) begin
         a_r1_add_sum:  assert (sum_o == wide_add[N-1:0]);
         a_r3_add_cout: assert (cout_o == wide_add[N]);
         a_r5_add_ovf:  assert (ovf_o == s_add_bad);
      end
      if (known && sub_i) begin
         a_r2_sub_sum:  assert (sum_o == s_sub[N-1:0]);
         a_r4_sub_cout: assert (cout_o == ({1'b0, a_i} >= wide_b_plus_c));
         a_r6_sub_ovf:  assert (ovf_o == s_sub_bad);
      end
   end
endmodule

bind lasa_addsub lasa_addsub_chk #(.N(N)) u_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .sub_i  (sub_i),
   .cin_i  (cin_i),
   .sum_o  (sum_o),
   .cout_o (cout_o),
   .ovf_o  (ovf_o)
);

// File: tb/lasa_addsub_bench.sv
module lasa_addsub_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a, b;
   logic         sub, cin;
   logic [W-1:0] sum;
   logic         cout, ovf;
   int           checks = 0;
   int           errors = 0;

   always #2 clk = ~clk;

   lasa_addsub #(.N(W)) u_lasa_addsub (
      .a_i(a), .b_i(b), .sub_i(sub), .cin_i(cin),
      .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
   );

   function automatic longint to_signed(input logic [W-1:0] v);
      return v[W-1] ? longint'(v) - (longint'(1) << W) : longint'(v);
   endfunction

   task automatic cmp(input string tag, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s a=%h b=%h sub=%0d cin=%0d got=%0h exp=%0h",
                  tag, what, a, b, sub, cin, got, exp);
      end
   endtask

   task automatic run_vec(input logic [W-1:0] va, input logic [W-1:0] vb,
                          input logic vs, input logic vc, input string extra);
      longint ua, ub, tot, esum, ecout, sres, eovf;
      longint mask = (longint'(1) << W) - 1;
      @(posedge clk); #1;
      a = va; b = vb; sub = vs; cin = vc;
      @(negedge clk);
      ua = longint'(va); ub = longint'(vb);
      if (!vs) begin
         tot   = ua + ub + longint'(vc);
         esum  = tot & mask;
         ecout = (tot >> W) & 1;
         sres  = to_signed(va) + to_signed(vb) + longint'(vc);
      end else begin
         tot   = ua - ub - longint'(vc);
         esum  = tot & mask;
         ecout = (ua >= ub + longint'(vc)) ? 1 : 0;
         sres  = to_signed(va) - to_signed(vb) - longint'(vc);
      end
      eovf = (sres > (longint'(1) << (W-1)) - 1 || sres < -(longint'(1) << (W-1))) ? 1 : 0;
      cmp(vs ? {"R2", extra} : {"R1", extra}, "sum",  longint'(sum),  esum);
      cmp(vs ? {"R4", extra} : {"R3", extra}, "cout", longint'(cout), ecout);
      cmp(vs ? {"R6", extra} : {"R5", extra}, "ovf",  longint'(ovf),  eovf);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] minv = {1'b1, {(W-1){1'b0}}};
      logic [W-1:0] maxv = {1'b0, {(W-1){1'b1}}};
      logic [W-1:0] ones = {W{1'b1}};
      a = '0; b = '0; sub = 1'b0; cin = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset-phase, all-zero operands: R1 zero sum, R3/R5 flags low
      cmp("R1", "reset sum",  longint'(sum),  0);
      cmp("R3", "reset cout", longint'(cout), 0);
      cmp("R5", "reset ovf",  longint'(ovf),  0);
      rst_n = 1'b1;

      // R7 corners
      run_vec(minv, ones, 1'b0, 1'b0, "/R7");
      cmp("R7", "min+-1 ovf",  longint'(ovf),  1);
      cmp("R7", "min+-1 cout", longint'(cout), 1);
      run_vec('0, minv, 1'b1, 1'b0, "/R7");
      cmp("R7", "0-min ovf", longint'(ovf), 1);
      cmp("R7", "0-min sum", longint'(sum), longint'(minv));
      // both flags at once
      run_vec(minv, minv, 1'b0, 1'b0, "");
      run_vec(maxv, 16'h0001, 1'b0, 1'b0, "");
      run_vec(maxv, '0, 1'b0, 1'b1, "");
      run_vec(ones, ones, 1'b0, 1'b1, "");
      run_vec(minv, 16'h0001, 1'b1, 1'b0, "");
      run_vec('0, '0, 1'b1, 1'b1, "");
      run_vec(maxv, ones, 1'b1, 1'b0, "");
      run_vec(16'h1234, 16'h1234, 1'b1, 1'b0, "");
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 4; j++) begin
            run_vec(16'h000F << (4*(i%4)), 16'h0001 << (4*j), i[0], i[1], "");
         end
      end
      for (int i = 0; i < 2000; i++) begin
         run_vec(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom), "");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule